// File: doc/BRIEF.md
# SD card SPI-mode block read receiver

This block takes over the SPI byte channel once a read command to an SD card in SPI mode has been accepted, and collects one or more fixed-size data blocks. For each block it keeps clocking idle bytes until the card answers with something other than an idle byte. It accepts only the single-block start token and rejects anything else. It then forwards the payload bytes on a valid/ready stream, reads the two trailing check bytes and compares them with a CRC16 it computes locally over the payload.

A start strobe loads the block count and block size. The block drives a separate byte-exchange engine through a request/done handshake, and it always transmits 0xFF. When the transfer ends it raises a one-cycle done pulse together with a two-bit status: success, bad token, CRC mismatch or token timeout. A parameter sets the timeout, counted in polls, and a second parameter decides whether CRC mismatches are enforced.

Top module: `sd_blk_rx`

## Requirements
- R1: Each byte exchange is requested by a one-cycle `xfer_req_o` pulse and sends 0xFF. No new request is made until `xfer_done_i` has returned the previous byte.
- R2: While hunting for a token, every 0xFF reply triggers another poll. The TIMEOUT_POLLS-th consecutive 0xFF reply of one hunt ends the transfer with status 3 (timeout). If a token arrives after fewer polls, the block proceeds.
- R3: A non-0xFF reply of 0xFE starts a block. Any other non-0xFF reply ends the transfer with status 1 (bad token) and no further exchanges.
- R4: After the token, exactly `blk_size_i` payload bytes and then two CRC bytes are exchanged, so one block costs polls + 1 + size + 2 exchanges.
- R5: Payload bytes appear on `dat_o` in arrival order, one per `dat_valid_o`/`dat_ready_i` handshake. `dat_o` holds steady while valid waits for ready, and no exchange is requested while a byte waits.
- R6: The reference CRC is CRC16 with polynomial 0x1021 and initial value 0, fed MSB first over the payload. The first CRC byte received is the high byte. With CRC_CHECK=1, a mismatch ends the transfer with status 2 right after that block's CRC bytes.
- R7: With CRC_CHECK=0, a CRC mismatch has no effect: the transfer continues and can end with status 0.
- R8: Blocks follow one another until `blk_cnt_i` blocks are complete, and then status 0 is reported. Every transfer ends with exactly one one-cycle `done_o` pulse, and `status_o` is valid during that pulse.
- R9: `start_i` and the count and size inputs are ignored while a transfer is in progress.
- R10: After reset, `xfer_req_o`, `dat_valid_o` and `done_o` are low and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| blk_cnt_i | input | CNT_W | Number of blocks, at least 1 |
| blk_size_i | input | SIZE_W | Payload bytes per block, at least 1 |
| xfer_req_o | output | 1 | Request one byte exchange |
| xfer_tx_o | output | 8 | Byte to transmit (always 0xFF) |
| xfer_done_i | input | 1 | Exchange complete, `xfer_rx_i` valid |
| xfer_rx_i | input | 8 | Byte received from the card |
| dat_o | output | 8 | Payload byte |
| dat_valid_o | output | 1 | Payload byte valid |
| dat_ready_i | input | 1 | Sink accepts payload byte |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| status_o | output | 2 | 0 ok, 1 bad token, 2 CRC error, 3 timeout |

## Verification
The embedded assertions watch the properties that hold cycle by cycle: single-cycle requests, a held stream byte with no request while it waits, the payload index staying inside the block, the poll counter staying below its limit, a cleared CRC after a token, and the done pulse width. Only the scenarios can show end-to-end results. These are the exact number of exchanges consumed, byte-for-byte payload order under random backpressure, the status chosen for each token value, timeout boundary and CRC corruption, and the different outcomes of the enforcing and non-enforcing instances on the same corrupted stream.

// File: rtl/sd_blk_rx_pkg.sv
package sd_blk_rx_pkg;

  typedef enum logic [1:0] {
    RX_OK        = 2'd0,
    RX_BAD_TOKEN = 2'd1,
    RX_CRC_ERR   = 2'd2,
    RX_TIMEOUT   = 2'd3
  } rx_status_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TOK_REQ,
    S_TOK_WAIT,
    S_PAY_REQ,
    S_PAY_WAIT,
    S_PAY_OUT,
    S_CRC_REQ,
    S_CRC_WAIT,
    S_FINISH
  } rx_state_e;

  localparam logic [7:0] IDLE_BYTE   = 8'hFF;
  localparam logic [7:0] START_TOKEN = 8'hFE;
  localparam logic [15:0] CRC_POLY   = 16'h1021;

  // one byte through the CRC16 shift register, MSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/sd_crc16.sv
module sd_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  import sd_blk_rx_pkg::*;

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc16_byte(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  a_r6_clear_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_o == 16'h0000);

endmodule

// File: rtl/sd_poll_timer.sv
module sd_poll_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int unsigned TW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [TW-1:0] cnt_q;

  assign hit_o = tick_i && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (tick_i && !hit_o)    cnt_q <= cnt_q + 1'b1;
  end

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < LIMIT);

endmodule

// File: rtl/sd_blk_rx.sv
module sd_blk_rx
  import sd_blk_rx_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned SIZE_W        = 10,
  parameter int unsigned TIMEOUT_POLLS = 3000000,
  parameter bit          CRC_CHECK     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  blk_cnt_i,
  input  logic [SIZE_W-1:0] blk_size_i,
  output logic              xfer_req_o,
  output logic [7:0]        xfer_tx_o,
  input  logic              xfer_done_i,
  input  logic [7:0]        xfer_rx_i,
  output logic [7:0]        dat_o,
  output logic              dat_valid_o,
  input  logic              dat_ready_i,
  output logic              done_o,
  output logic [1:0]        status_o
);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  blk_left_q;
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] idx_q;
  logic [7:0]        dat_q;
  logic [7:0]        crc_hi_q;
  logic              crc_sel_q;
  rx_status_e        status_q;

  logic        rx_idle, rx_start;
  logic        poll_tick, poll_clr, poll_hit;
  logic        crc_clr, crc_en;
  logic [15:0] crc_calc;
  logic        crc_bad;

  assign rx_idle  = (xfer_rx_i == IDLE_BYTE);
  assign rx_start = (xfer_rx_i == START_TOKEN);

  assign poll_tick = (state_q == S_TOK_WAIT) && xfer_done_i && rx_idle;
  assign poll_clr  = (state_q == S_IDLE) ||
                     ((state_q == S_TOK_WAIT) && xfer_done_i && !rx_idle);
  assign crc_clr   = (state_q == S_TOK_WAIT) && xfer_done_i && rx_start;
  assign crc_en    = (state_q == S_PAY_WAIT) && xfer_done_i;
  assign crc_bad   = CRC_CHECK && ({crc_hi_q, xfer_rx_i} != crc_calc);

  sd_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .tick_i (poll_tick),
    .hit_o  (poll_hit)
  );

  sd_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .byte_i (xfer_rx_i),
    .crc_o  (crc_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      blk_left_q <= '0;
      size_q     <= '0;
      idx_q      <= '0;
      dat_q      <= '0;
      crc_hi_q   <= '0;
      crc_sel_q  <= 1'b0;
      status_q   <= RX_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          size_q     <= blk_size_i;
          blk_left_q <= blk_cnt_i;
          state_q    <= S_TOK_REQ;
        end
        S_TOK_REQ: state_q <= S_TOK_WAIT;
        S_TOK_WAIT: if (xfer_done_i) begin
          if (rx_idle) begin
            if (poll_hit) begin
              status_q <= RX_TIMEOUT;
              state_q  <= S_FINISH;
            end else begin
              state_q  <= S_TOK_REQ;
            end
          end else if (rx_start) begin
            idx_q   <= '0;
            state_q <= S_PAY_REQ;
          end else begin
            status_q <= RX_BAD_TOKEN;
            state_q  <= S_FINISH;
          end
        end
        S_PAY_REQ: state_q <= S_PAY_WAIT;
        S_PAY_WAIT: if (xfer_done_i) begin
          dat_q   <= xfer_rx_i;
          state_q <= S_PAY_OUT;
        end
        S_PAY_OUT: if (dat_ready_i) begin
          if (idx_q == size_q - 1'b1) begin
            crc_sel_q <= 1'b0;
            state_q   <= S_CRC_REQ;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_PAY_REQ;
          end
        end
        S_CRC_REQ: state_q <= S_CRC_WAIT;
        S_CRC_WAIT: if (xfer_done_i) begin
          if (!crc_sel_q) begin
            crc_hi_q  <= xfer_rx_i;
            crc_sel_q <= 1'b1;
            state_q   <= S_CRC_REQ;
          end else if (crc_bad) begin
            status_q <= RX_CRC_ERR;
            state_q  <= S_FINISH;
          end else if (blk_left_q == CNT_W'(1)) begin
            status_q <= RX_OK;
            state_q  <= S_FINISH;
          end else begin
            blk_left_q <= blk_left_q - 1'b1;
            state_q    <= S_TOK_REQ;
          end
        end
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign xfer_req_o  = (state_q == S_TOK_REQ) || (state_q == S_PAY_REQ) ||
                       (state_q == S_CRC_REQ);
  assign xfer_tx_o   = IDLE_BYTE;
  assign dat_o       = dat_q;
  assign dat_valid_o = (state_q == S_PAY_OUT);
  assign done_o      = (state_q == S_FINISH);
  assign status_o    = status_q;

  a_r1_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |=> !xfer_req_o);

  a_r5_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_valid_o && !dat_ready_i) |=> (dat_valid_o && $stable(dat_o)));

  a_r5_no_req_while_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_valid_o |-> !xfer_req_o);

  a_r4_idx_in_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_valid_o |-> (idx_q < size_q));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_size_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && start_i) |=> $stable(size_q));

endmodule

// File: tb/sd_spi_card_stub.sv
module sd_spi_card_stub #(
  parameter int unsigned LAT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       req_i,
  input  logic [7:0] byte_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic [8:0] ptr_o
);
  logic [3:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_o <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ptr_o <= '0;
    end else begin
      if (req_i)           cnt_q <= 4'(LAT);
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
      if (cnt_q == 4'd1)   ptr_o <= ptr_o + 1'b1;
    end
  end

  assign done_o = (cnt_q == 4'd1);
  assign rx_o   = byte_i;

endmodule

// File: tb/sd_blk_rx_test.sv
module sd_blk_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 3;
  localparam int SIZE_W = 4;
  localparam int TMO    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              start = 1'b0;
  logic [CNT_W-1:0]  blk_cnt = '0;
  logic [SIZE_W-1:0] blk_size = '0;
  logic              ready = 1'b1;
  logic              card_clr = 1'b0;

  logic       req_a, req_b, done_xa, done_xb, valid_a, valid_b, done_a_o, done_b_o;
  logic [7:0] tx_a, tx_b, rx_a, rx_b, dat_a, dat_b, byte_a, byte_b;
  logic [1:0] st_a_o, st_b_o;
  logic [8:0] ptr_a, ptr_b;

  logic [7:0] script [0:511];
  logic [7:0] exp_pay [0:63];
  int slen, exp_beats;

  assign byte_a = script[ptr_a];
  assign byte_b = script[ptr_b];

  sd_blk_rx #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .TIMEOUT_POLLS(TMO), .CRC_CHECK(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_cnt_i(blk_cnt), .blk_size_i(blk_size),
    .xfer_req_o(req_a), .xfer_tx_o(tx_a), .xfer_done_i(done_xa), .xfer_rx_i(rx_a),
    .dat_o(dat_a), .dat_valid_o(valid_a), .dat_ready_i(ready), .done_o(done_a_o), .status_o(st_a_o));

  sd_blk_rx #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .TIMEOUT_POLLS(TMO), .CRC_CHECK(1'b0)) uut_nc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_cnt_i(blk_cnt), .blk_size_i(blk_size),
    .xfer_req_o(req_b), .xfer_tx_o(tx_b), .xfer_done_i(done_xb), .xfer_rx_i(rx_b),
    .dat_o(dat_b), .dat_valid_o(valid_b), .dat_ready_i(ready), .done_o(done_b_o), .status_o(st_b_o));

  sd_spi_card_stub #(.LAT(2)) card_a (.clk_i(clk), .rst_ni(rst_n), .clr_i(card_clr), .req_i(req_a),
    .byte_i(byte_a), .done_o(done_xa), .rx_o(rx_a), .ptr_o(ptr_a));
  sd_spi_card_stub #(.LAT(3)) card_b (.clk_i(clk), .rst_ni(rst_n), .clr_i(card_clr), .req_i(req_b),
    .byte_i(byte_b), .done_o(done_xb), .rx_o(rx_b), .ptr_o(ptr_b));

  int n_chk = 0, n_err = 0;
  int beats, bad_beats, ndone_a, ndone_b;
  logic [1:0] got_a, got_b;
  logic tx_bad;
  logic [7:0] lfsr = 8'h5A;

  // sink, done and transmit-byte monitor
  always @(negedge clk) begin
    lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ready = lfsr[0] | lfsr[2];
    if (valid_a && ready) begin
      if (beats >= 64 || dat_a !== exp_pay[beats]) bad_beats++;
      beats++;
    end
    if (done_a_o) begin ndone_a++; got_a = st_a_o; end
    if (done_b_o) begin ndone_b++; got_b = st_b_o; end
    if ((req_a && tx_a !== 8'hFF) || (req_b && tx_b !== 8'hFF)) tx_bad = 1'b1;
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[15] ^ d[7-i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic clear_script();
    for (int i = 0; i < 512; i++) script[i] = 8'hFF;
    slen = 0;
    exp_beats = 0;
  endtask

  task automatic push(input logic [7:0] b);
    script[slen] = b;
    slen++;
  endtask

  task automatic add_block(input int nff, input int size, input int seed, input logic [15:0] corrupt);
    logic [15:0] c;
    logic [7:0] b;
    for (int i = 0; i < nff; i++) push(8'hFF);
    push(8'hFE);
    c = 16'h0000;
    for (int k = 0; k < size; k++) begin
      b = 8'((seed * 29 + k * 13 + 7) & 255);
      exp_pay[exp_beats] = b;
      exp_beats++;
      c = crc_ref(c, b);
      push(b);
    end
    c = c ^ corrupt;
    push(c[15:8]);
    push(c[7:0]);
  endtask

  task automatic run(input string tag, input int cnt, input int size,
                     input int est_a, input int est_b, input int eptr_a, input int eptr_b,
                     input int ebeats, input bit mid);
    int w;
    @(negedge clk);
    card_clr = 1'b1;
    beats = 0; bad_beats = 0; ndone_a = 0; ndone_b = 0; tx_bad = 1'b0;
    got_a = 2'd0; got_b = 2'd0;
    @(negedge clk);
    card_clr = 1'b0;
    blk_cnt  = CNT_W'(cnt);
    blk_size = SIZE_W'(size);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid) begin
      repeat (6) @(negedge clk);
      blk_cnt  = 3'd7;
      blk_size = 4'd1;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while ((ndone_a == 0 || ndone_b == 0) && w < 20000) begin
      @(negedge clk);
      w++;
    end
    repeat (4) @(negedge clk);
    chk({tag, " R8 finished"}, int'(w < 20000), 1);
    chk({tag, " R8 one done pulse"}, ndone_a, 1);
    chk({tag, " R8 one done pulse nc"}, ndone_b, 1);
    chk({tag, " status"}, int'(got_a), est_a);
    chk({tag, " R7 status nc"}, int'(got_b), est_b);
    chk({tag, " R4 exchanges"}, int'(ptr_a), eptr_a);
    chk({tag, " R4 exchanges nc"}, int'(ptr_b), eptr_b);
    chk({tag, " R5 beat count"}, beats, ebeats);
    chk({tag, " R5 payload order"}, bad_beats, 0);
    chk({tag, " R1 idle tx byte"}, int'(tx_bad), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int p;
    clear_script();
    beats = 0; bad_beats = 0; ndone_a = 0; ndone_b = 0; tx_bad = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 req", int'(req_a), 0);
    chk("R10 valid", int'(valid_a), 0);
    chk("R10 done", int'(done_a_o), 0);
    chk("R10 status", int'(st_a_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 idle after release", int'(req_a | valid_a | done_a_o), 0);

    // R8 sweep of counts and sizes, varying leading idle bytes
    for (int c = 1; c <= 3; c++) begin
      for (int si = 0; si < 5; si++) begin
        int s;
        s = (si == 0) ? 1 : (si == 1) ? 2 : (si == 2) ? 3 : (si == 3) ? 5 : 15;
        clear_script();
        for (int b = 0; b < c; b++) add_block((b + s) % 4, s, c * 16 + b + s, 16'h0000);
        run("R8 sweep", c, s, 0, 0, slen, slen, c * s, 1'b0);
      end
    end

    // R2 one poll short of the limit
    clear_script();
    add_block(TMO - 1, 4, 3, 16'h0000);
    run("R2 below limit", 1, 4, 0, 0, slen, slen, 4, 1'b0);

    // R2 limit reached on first block
    clear_script();
    for (int i = 0; i < TMO; i++) push(8'hFF);
    run("R2 timeout", 1, 4, 3, 3, TMO, TMO, 0, 1'b0);

    // R2 limit reached on second block
    clear_script();
    add_block(0, 3, 9, 16'h0000);
    for (int i = 0; i < TMO; i++) push(8'hFF);
    run("R2 timeout blk2", 2, 3, 3, 3, slen, slen, 3, 1'b0);

    // R3 bad tokens
    clear_script();
    push(8'hFF); push(8'hFF); push(8'hFC);
    run("R3 token FC", 1, 2, 1, 1, 3, 3, 0, 1'b0);
    clear_script();
    add_block(1, 2, 5, 16'h0000);
    push(8'h00);
    run("R3 token 00", 3, 2, 1, 1, slen, slen, 2, 1'b0);
    clear_script();
    push(8'hFD);
    run("R3 token FD", 1, 1, 1, 1, 1, 1, 0, 1'b0);

    // R6 low-byte corruption in block 2; R7 nc instance continues
    clear_script();
    add_block(0, 5, 1, 16'h0000);
    add_block(2, 5, 2, 16'h0001);
    p = slen;
    add_block(1, 5, 3, 16'h0000);
    run("R6 crc lo", 3, 5, 2, 0, p, slen, 10, 1'b0);

    // R6 high-byte corruption, single block
    clear_script();
    add_block(0, 1, 4, 16'h8000);
    run("R6 crc hi", 1, 1, 2, 0, slen, slen, 1, 1'b0);

    // R9 start while busy ignored
    clear_script();
    add_block(2, 6, 11, 16'h0000);
    add_block(0, 6, 12, 16'h0000);
    run("R9 restart ignored", 2, 6, 0, 0, slen, slen, 12, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule